// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This unit sorts a recorded control-flow transfer into a class. It receives the first opcode bytes of the source instruction, the ModRM byte, a flag telling whether a 32-bit relative displacement is zero, the source and target addresses with their privilege levels, a transactional-abort flag and a flag saying whether the opcode bytes could be fetched at all. It produces a mask with at most one class bit and at most one privilege bit. Branch-record filters compare this mask against a requested set of classes.

A user-to-kernel transfer whose source instruction is not a deliberate ring-entry instruction is folded into the hardware-interrupt class. A near relative call with a zero displacement gets a class of its own. The result is registered, so it appears one cycle after the qualifying input strobe.

Top module: `br_type_classifier`

## Requirements
- R1: The mask is 14 bits wide. Bit 0 is user target and bit 1 is kernel target. The class bits are: 2 conditional, 3 jump, 4 call, 5 indirect call, 6 zero-length call, 7 return, 8 interrupt return, 9 system call, 10 system return, 11 software interrupt, 12 hardware interrupt, 13 abort. At most one class bit and at most one privilege bit are set. NONE is all zeros.
- R2: If the abort flag is set and both addresses are non-zero, the mask is abort ORed with the target privilege bit, whatever the opcode bytes and the opcode-valid flag say.
- R3: If abort is clear, both addresses are non-zero and the opcode-valid flag is low, the mask is the abort bit alone, with no privilege bit.
- R4: A lead byte of 0x0F selects the escape map on the second byte. 0x05 and 0x34 give system call, 0x07 and 0x35 give system return, 0x80 to 0x8F give conditional, and any other second byte gives NONE.
- R5: Single-byte lead values map as follows: 0x70 to 0x7F and 0xE0 to 0xE3 give conditional; 0xC2, 0xC3, 0xCA and 0xCB give return; 0xCF gives interrupt return; 0xCC to 0xCE give software interrupt; 0xE9 to 0xEB give jump; 0x9A gives call.
- R6: Lead byte 0xE8 gives call when the displacement-zero flag is low and zero-length call when it is high.
- R7: For lead byte 0xFF, ModRM bits 5:3 equal to 2 or 3 give indirect call, 4 or 5 give jump, and any other value gives NONE.
- R8: When the source is user and the target is kernel, the decoded class is replaced by hardware interrupt unless it is system call or software interrupt. This also applies when decoding gives NONE.
- R9: Any non-NONE decoded result (R4 to R8) also carries the target privilege bit. Lead bytes not listed above give NONE when R8 does not apply.
- R10: A source or target address of zero gives NONE, and this takes priority over abort.
- R11: `out_valid` and `type_mask` update one cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_valid` is low and `type_mask` holds its value. Synchronous reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| lead_byte | input | 8 | First opcode byte |
| second_byte | input | 8 | Byte after a 0x0F escape |
| modrm_byte | input | 8 | ModRM byte |
| imm_is_zero | input | 1 | 32-bit relative displacement is zero |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Target address |
| src_kernel | input | 1 | Source is kernel privilege |
| dst_kernel | input | 1 | Target is kernel privilege |
| abort_flag | input | 1 | Record marks a transactional abort |
| opcode_ok | input | 1 | Opcode bytes were obtained |
| out_valid | output | 1 | Result strobe |
| type_mask | output | 14 | Class plus privilege mask (R1 layout) |

## Verification
The assertions assume that the inputs are known values whenever `in_valid` is high. They also assume that the privilege flags agree with the addresses, as an upstream address decode would ensure. The stimulus keeps both addresses non-zero except in the directed zero-address cases, and it changes inputs only on the falling clock edge. The hold property assumes that nothing but `in_valid` or reset moves the output register, and the hold test deliberately changes every other input while the strobe is low.

// File: rtl/br_cls_pkg.sv
package br_cls_pkg;

    localparam int MASK_W  = 14;
    localparam int B_USER  = 0;
    localparam int B_KERN  = 1;
    localparam int B_COND  = 2;
    localparam int B_JMP   = 3;
    localparam int B_CALL  = 4;
    localparam int B_ICALL = 5;
    localparam int B_ZCALL = 6;
    localparam int B_RET   = 7;
    localparam int B_IRET  = 8;
    localparam int B_SYSC  = 9;
    localparam int B_SYSR  = 10;
    localparam int B_SWINT = 11;
    localparam int B_HWINT = 12;
    localparam int B_ABORT = 13;

    typedef logic [MASK_W-1:0] brmask_t;

    typedef struct packed {
        logic [7:0] lead;
        logic [7:0] second;
        logic [7:0] modrm;
        logic       imm_zero;
    } opc_t;

    function automatic brmask_t bit_of(input int idx);
        brmask_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic brmask_t priv_bit(input logic kern);
        return kern ? bit_of(B_KERN) : bit_of(B_USER);
    endfunction

endpackage

// File: rtl/br_op_decode.sv
module br_op_decode
    import br_cls_pkg::*;
(
    input  opc_t    opc,
    output brmask_t cls
);
    always_comb begin
        cls = '0;
        case (opc.lead) inside
            8'h0F: begin
                case (opc.second) inside
                    8'h05, 8'h34:  cls = bit_of(B_SYSC);
                    8'h07, 8'h35:  cls = bit_of(B_SYSR);
                    [8'h80:8'h8F]: cls = bit_of(B_COND);
                    default:       cls = '0;
                endcase
            end
            [8'h70:8'h7F], [8'hE0:8'hE3]: cls = bit_of(B_COND);
            8'hC2, 8'hC3, 8'hCA, 8'hCB:   cls = bit_of(B_RET);
            8'hCF:                        cls = bit_of(B_IRET);
            [8'hCC:8'hCE]:                cls = bit_of(B_SWINT);
            [8'hE9:8'hEB]:                cls = bit_of(B_JMP);
            8'h9A:                        cls = bit_of(B_CALL);
            8'hE8: cls = opc.imm_zero ? bit_of(B_ZCALL) : bit_of(B_CALL);
            8'hFF: begin
                case (opc.modrm[5:3])
                    3'd2, 3'd3: cls = bit_of(B_ICALL);
                    3'd4, 3'd5: cls = bit_of(B_JMP);
                    default:    cls = '0;
                endcase
            end
            default: cls = '0;
        endcase
    end
endmodule

// File: rtl/br_priv_fold.sv
module br_priv_fold
    import br_cls_pkg::*;
#(
    parameter int AW = 64
) (
    input  brmask_t         cls,
    input  logic [AW-1:0]   src_addr,
    input  logic [AW-1:0]   dst_addr,
    input  logic            src_kernel,
    input  logic            dst_kernel,
    input  logic            abort_flag,
    input  logic            opcode_ok,
    output brmask_t         result
);
    brmask_t plm;
    brmask_t folded;
    logic    ring_entry;

    assign plm        = priv_bit(dst_kernel);
    assign ring_entry = !src_kernel && dst_kernel;

    always_comb begin
        folded = cls;
        if (ring_entry && !cls[B_SYSC] && !cls[B_SWINT])
            folded = bit_of(B_HWINT);
    end

    always_comb begin
        if (src_addr == '0 || dst_addr == '0)
            result = '0;
        else if (abort_flag)
            result = bit_of(B_ABORT) | plm;
        else if (!opcode_ok)
            result = bit_of(B_ABORT);
        else if (folded != '0)
            result = folded | plm;
        else
            result = '0;
    end
endmodule

// File: rtl/br_type_classifier.sv
module br_type_classifier
    import br_cls_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          lead_byte,
    input  logic [7:0]          second_byte,
    input  logic [7:0]          modrm_byte,
    input  logic                imm_is_zero,
    input  logic [AW-1:0]       src_addr,
    input  logic [AW-1:0]       dst_addr,
    input  logic                src_kernel,
    input  logic                dst_kernel,
    input  logic                abort_flag,
    input  logic                opcode_ok,
    output logic                out_valid,
    output logic [MASK_W-1:0]   type_mask
);
    opc_t    opc;
    brmask_t cls;
    brmask_t next_mask;

    assign opc = '{lead: lead_byte, second: second_byte,
                   modrm: modrm_byte, imm_zero: imm_is_zero};

    br_op_decode u_dec (
        .opc (opc),
        .cls (cls)
    );

    br_priv_fold #(.AW(AW)) u_fold (
        .cls        (cls),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .src_kernel (src_kernel),
        .dst_kernel (dst_kernel),
        .abort_flag (abort_flag),
        .opcode_ok  (opcode_ok),
        .result     (next_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            type_mask <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                type_mask <= next_mask;
        end
    end

    // R1: at most one class bit and one privilege bit
    a_r1_mask_shape: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($onehot0(type_mask[MASK_W-1:2]) && $onehot0(type_mask[1:0])));

    // R2: abort wins over opcode content
    a_r2_abort_priv: assert property (@(posedge clk) disable iff (rst)
        (in_valid && abort_flag && src_addr != '0 && dst_addr != '0)
        |=> (type_mask == (bit_of(B_ABORT) | priv_bit($past(dst_kernel)))));

    // R3: missing opcode yields bare abort
    a_r3_no_opcode: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !abort_flag && !opcode_ok && src_addr != '0 && dst_addr != '0)
        |=> (type_mask == bit_of(B_ABORT)));

    // R10: zero address gives NONE
    a_r10_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (src_addr == '0 || dst_addr == '0)) |=> (type_mask == '0));

    // R11: one-cycle strobe and hold
    a_r11_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(type_mask)));

endmodule

// File: tb/test_br_type_classifier.sv
`timescale 1ns/1ps
module test_br_type_classifier;

    localparam int AW = 64;
    localparam logic [13:0] U  = 14'h0001, K  = 14'h0002, CO = 14'h0004,
                            JM = 14'h0008, CA = 14'h0010, IC = 14'h0020,
                            ZC = 14'h0040, RT = 14'h0080, IR = 14'h0100,
                            SC = 14'h0200, SR = 14'h0400, SW = 14'h0800,
                            HW = 14'h1000, AB = 14'h2000;

    typedef struct packed {
        logic [7:0]  lead;
        logic [7:0]  second;
        logic [7:0]  modrm;
        logic        iz;
        logic        fk;
        logic        tk;
        logic        ab;
        logic        ok;
        logic [13:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{8'h0F, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SC|U, 8'd4}, // R4
        '{8'h0F, 8'h34, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, SC|K, 8'd4},
        '{8'h0F, 8'h07, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, SR|U, 8'd4},
        '{8'h0F, 8'h35, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, SR|K, 8'd4},
        '{8'h0F, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CO|U, 8'd4},
        '{8'h0F, 8'h8F, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CO|U, 8'd4},
        '{8'h0F, 8'h90, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, 8'd4},
        '{8'h70, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CO|U, 8'd5}, // R5
        '{8'h7F, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, CO|K, 8'd5},
        '{8'hE3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CO|U, 8'd5},
        '{8'hC2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, RT|U, 8'd5},
        '{8'hCB, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, RT|K, 8'd5},
        '{8'hCF, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, IR|U, 8'd5},
        '{8'hCC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SW|U, 8'd5},
        '{8'hE9, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, JM|U, 8'd5},
        '{8'hEB, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, JM|K, 8'd5},
        '{8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CA|U, 8'd5},
        '{8'hE8, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CA|U, 8'd6}, // R6
        '{8'hE8, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ZC|U, 8'd6},
        '{8'hFF, 8'h00, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, IC|U, 8'd7}, // R7
        '{8'hFF, 8'h00, 8'hDF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, IC|K, 8'd7},
        '{8'hFF, 8'h00, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, JM|U, 8'd7},
        '{8'hFF, 8'h00, 8'h28, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, JM|U, 8'd7},
        '{8'hFF, 8'h00, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, 8'd7},
        '{8'hFF, 8'h00, 8'hC7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, 8'd7},
        '{8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0, 8'd9}, // R9
        '{8'hC8, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0, 8'd9},
        '{8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, HW|K, 8'd8}, // R8
        '{8'h74, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, HW|K, 8'd8},
        '{8'h0F, 8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, SC|K, 8'd8},
        '{8'hCD, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, SW|K, 8'd8},
        '{8'h74, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AB|U, 8'd2}, // R2
        '{8'hE8, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, AB|K, 8'd2},
        '{8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AB|K, 8'd2},
        '{8'h74, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AB,   8'd3}, // R3
        '{8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AB,   8'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] lead_byte = '0, second_byte = '0, modrm_byte = '0;
    logic imm_is_zero = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic src_kernel = 1'b0, dst_kernel = 1'b0, abort_flag = 1'b0, opcode_ok = 1'b0;
    logic out_valid;
    logic [13:0] type_mask;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    br_type_classifier #(.AW(AW)) i_br_type_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .lead_byte(lead_byte), .second_byte(second_byte), .modrm_byte(modrm_byte),
        .imm_is_zero(imm_is_zero), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_kernel(src_kernel), .dst_kernel(dst_kernel),
        .abort_flag(abort_flag), .opcode_ok(opcode_ok),
        .out_valid(out_valid), .type_mask(type_mask)
    );

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic [AW-1:0] fa, input logic [AW-1:0] ta);
        lead_byte = v.lead; second_byte = v.second; modrm_byte = v.modrm;
        imm_is_zero = v.iz; src_kernel = v.fk; dst_kernel = v.tk;
        abort_flag = v.ab; opcode_ok = v.ok;
        src_addr = fa; dst_addr = ta;
    endtask

    function automatic logic [AW-1:0] addr_of(input logic kern);
        return kern ? 64'hFFFF_8000_0010_2000 : 64'h0000_0000_0040_1000;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset valid", {13'd0, out_valid}, 14'd0);
        check("R11 reset mask", type_mask, 14'd0);
        rst = 1'b0;

        // table walk: R1 layout, R2..R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i], addr_of(VEC[i].fk), addr_of(VEC[i].tk));
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d R1 vec %0d", VEC[i].req, i), type_mask, VEC[i].exp);
            check($sformatf("R11 strobe vec %0d", i), {13'd0, out_valid}, 14'd1);
        end

        // R10: zero source address beats abort
        @(negedge clk);
        drive(VEC[31], '0, addr_of(1'b0));
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 zero source with abort", type_mask, 14'd0);

        // R10: zero target on a valid jump
        @(negedge clk);
        drive(VEC[14], addr_of(1'b0), '0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 zero target", type_mask, 14'd0);

        // R11: load a value, then move every input with strobe low
        @(negedge clk);
        drive(VEC[10], addr_of(1'b0), addr_of(1'b0));
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 load before hold", type_mask, RT|U);
        drive(VEC[21], addr_of(1'b1), addr_of(1'b1));
        @(negedge clk);
        drive(VEC[27], addr_of(1'b0), addr_of(1'b1));
        @(negedge clk);
        check("R11 hold mask", type_mask, RT|U);
        check("R11 hold valid low", {13'd0, out_valid}, 14'd0);

        // R11: reset mid-run clears the result
        rst = 1'b1;
        @(negedge clk);
        check("R11 mid reset mask", type_mask, 14'd0);
        rst = 1'b0;

        // R6 back-to-back strobes
        @(negedge clk);
        drive(VEC[18], addr_of(1'b0), addr_of(1'b0));
        in_valid = 1'b1;
        @(negedge clk);
        check("R6 zero call first", type_mask, ZC|U);
        drive(VEC[17], addr_of(1'b0), addr_of(1'b0));
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 call second", type_mask, CA|U);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule